// File: doc/BRIEF.md
# VLAN membership table controller

This block keeps one entry per VLAN identifier, 4096 of them at the default width. An entry holds a member mask of ten ports and six one-bit control flags. Nine bits of the mask are front ports; the top bit is the CPU port. Software reaches the table through three registers: an index register that holds the VID, the flags and a CPU-disable bit; a mask register; and a command register. A command starts a read, a write or a full initialise. While a command is in progress the command field reads non-idle, so software polls it until it returns to zero.

The forwarding path has its own lookup port. A request carries a VID and, one clock later, returns that entry's mask and flags. While the initialise sweep runs, every lookup returns the all-members value, whatever the entry holds at that moment.

Top module: `vlan_tbl_ctrl`

## Requirements
- R1: After reset, the index, mask and command registers read as zero and `lk_valid` is low.
- R2: The command field is bits [1:0] of register address 2, with 0 meaning idle, 1 read, 2 write and 3 initialise. Writing idle starts nothing and leaves the other registers unchanged.
- R3: A write command stores the index register's flags and the mask register into the entry chosen by the VID. The index register (address 0) holds the VID in bits [11:0], the flags in bits [17:12] and CPU-disable in bit 18. The flag order from bit 12 upward is source check, mirror, learning disable, private VLAN, flood disable, secondary forward enable. The mask register (address 1) holds the mask in bits [9:0], with bit 9 the CPU port. When CPU-disable is set, the stored CPU bit is 0.
- R4: A read command loads the selected entry's flags and mask into the index and mask registers. It sets CPU-disable exactly when the entry's CPU bit is 0, and it leaves the VID unchanged.
- R5: For a read or a write, the command field shows the command for exactly one sample after the clock edge that accepts it, and reads idle from the next sample on.
- R6: After an initialise, every entry has all ten mask bits set and all flags clear.
- R7: After an initialise is accepted, the command field reads 3 for exactly 4096 consecutive cycles, one entry per clock, and then reads 0.
- R8: While the command field is non-idle, software writes to any register are ignored, and no command is queued for later.
- R9: A lookup request sampled on a clock edge makes `lk_valid` high after that edge, with the entry's mask and flags. An edge with no request makes `lk_valid` low.
- R10: A lookup sampled during the initialise sweep returns mask 0x3FF and flags 0, even for an entry the sweep has not yet reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 index, 1 mask, 2 command |
| reg_wdata | input | 19 | Register write data |
| reg_rdata | output | 19 | Read data of the register selected by reg_addr |
| lk_req | input | 1 | Lookup request |
| lk_vid | input | 12 | Lookup VID |
| lk_valid | output | 1 | Lookup result valid |
| lk_mask | output | 10 | Member mask of the looked-up VID |
| lk_flags | output | 6 | Control flags of the looked-up VID |

## Verification
A sequencer stuck non-idle, or one that returns to idle too early, shows up in the command field at the very next sample. A sweep length off by a single cycle changes the measured busy count of 4096. A wrong write path or field mapping shows up one command later, when the entry is read back into the registers and looked up on the forwarding port. A sweep-time lookup that leaks stale content, or a command accepted while busy, shows up as a non-member mask or as an index register that has changed across the sweep.

// File: rtl/vlan_tbl_pkg.sv
package vlan_tbl_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_INIT  = 2'd3
  } vcmd_e;

  localparam logic [1:0] ADDR_IDX  = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_CMD  = 2'd2;

endpackage

// File: rtl/vlan_tbl_store.sv
module vlan_tbl_store #(
  parameter int VID_W = 12,
  parameter int ENT_W = 16
) (
  input  logic             clk,
  input  logic             we,
  input  logic [VID_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [VID_W-1:0] raddr_a,
  output logic [ENT_W-1:0] rdata_a,
  input  logic [VID_W-1:0] raddr_b,
  output logic [ENT_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << VID_W;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/vlan_cmd_seq.sv
module vlan_cmd_seq
  import vlan_tbl_pkg::*;
#(
  parameter int VID_W  = 12,
  parameter int PORT_W = 10,
  parameter int FLAG_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [1:0]                 reg_addr,
  input  logic [VID_W+FLAG_W:0]      reg_wdata,
  output logic [VID_W+FLAG_W:0]      reg_rdata,
  output logic                       tbl_we,
  output logic [VID_W-1:0]           tbl_waddr,
  output logic [FLAG_W+PORT_W-1:0]   tbl_wdata,
  output logic [VID_W-1:0]           tbl_raddr,
  input  logic [FLAG_W+PORT_W-1:0]   tbl_rdata,
  output logic                       sweep_act
);
  localparam int REG_W    = VID_W + FLAG_W + 1;
  localparam int ENT_W    = FLAG_W + PORT_W;
  localparam int FLAG_LSB = VID_W;
  localparam int CDIS_BIT = VID_W + FLAG_W;
  localparam int CPU_BIT  = PORT_W - 1;
  localparam logic [VID_W-1:0] LAST_VID = {VID_W{1'b1}};

  // Entry value the initialise sweep writes: every port a member, no flags.
  function automatic logic [ENT_W-1:0] all_members();
    return {{FLAG_W{1'b0}}, {PORT_W{1'b1}}};
  endfunction

  // Entry assembled from the software registers; CPU-disable removes the CPU port.
  function automatic logic [ENT_W-1:0] entry_from_regs(
    input logic [FLAG_W-1:0] flg, input logic [PORT_W-1:0] msk, input logic cdis);
    logic [PORT_W-1:0] m;
    m = msk;
    if (cdis) m[CPU_BIT] = 1'b0;
    return {flg, m};
  endfunction

  logic [VID_W-1:0]  vid_q;
  logic [FLAG_W-1:0] flags_q;
  logic              cdis_q;
  logic [PORT_W-1:0] mask_q;
  vcmd_e             cmd_q;
  logic [VID_W-1:0]  sweep_q;

  logic busy;
  logic sw_take;
  logic rd_done;
  logic sweep_last;

  assign busy       = (cmd_q != CMD_IDLE);
  assign sw_take    = reg_wr && !busy;
  assign rd_done    = (cmd_q == CMD_READ);
  assign sweep_act  = (cmd_q == CMD_INIT);
  assign sweep_last = sweep_act && (sweep_q == LAST_VID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid_q   <= '0;
      flags_q <= '0;
      cdis_q  <= 1'b0;
      mask_q  <= '0;
      cmd_q   <= CMD_IDLE;
      sweep_q <= '0;
    end else begin
      if (sw_take) begin
        case (reg_addr)
          ADDR_IDX: begin
            vid_q   <= reg_wdata[VID_W-1:0];
            flags_q <= reg_wdata[FLAG_LSB +: FLAG_W];
            cdis_q  <= reg_wdata[CDIS_BIT];
          end
          ADDR_MASK: mask_q <= reg_wdata[PORT_W-1:0];
          ADDR_CMD: begin
            cmd_q   <= vcmd_e'(reg_wdata[1:0]);
            sweep_q <= '0;
          end
          default: ;
        endcase
      end
      case (cmd_q)
        CMD_READ: begin
          mask_q  <= tbl_rdata[PORT_W-1:0];
          flags_q <= tbl_rdata[PORT_W +: FLAG_W];
          cdis_q  <= ~tbl_rdata[CPU_BIT];
          cmd_q   <= CMD_IDLE;
        end
        CMD_WRITE: cmd_q <= CMD_IDLE;
        CMD_INIT: begin
          sweep_q <= sweep_q + 1'b1;
          if (sweep_last) cmd_q <= CMD_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign tbl_we    = (cmd_q == CMD_WRITE) || sweep_act;
  assign tbl_waddr = sweep_act ? sweep_q : vid_q;
  assign tbl_wdata = sweep_act ? all_members() : entry_from_regs(flags_q, mask_q, cdis_q);
  assign tbl_raddr = vid_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_IDX: begin
        reg_rdata[VID_W-1:0]            = vid_q;
        reg_rdata[FLAG_LSB +: FLAG_W]   = flags_q;
        reg_rdata[CDIS_BIT]             = cdis_q;
      end
      ADDR_MASK: reg_rdata[PORT_W-1:0]  = mask_q;
      ADDR_CMD:  reg_rdata[1:0]         = cmd_q;
      default:   reg_rdata              = '0;
    endcase
  end

  initial begin
    assert (REG_W >= PORT_W);
  end

  AST_RW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_READ || cmd_q == CMD_WRITE) |=> (cmd_q == CMD_IDLE)); // R5

  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> $stable(vid_q)); // R8

  AST_READ_CDIS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (cdis_q == !mask_q[CPU_BIT])); // R4

  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_act && !sweep_last) |=> (sweep_act && sweep_q == $past(sweep_q) + 1'b1)); // R7

  AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_last |=> (cmd_q == CMD_IDLE)); // R7

endmodule

// File: rtl/vlan_lookup.sv
module vlan_lookup #(
  parameter int VID_W  = 12,
  parameter int PORT_W = 10,
  parameter int FLAG_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_req,
  input  logic [VID_W-1:0]         lk_vid,
  input  logic                     sweep_act,
  output logic [VID_W-1:0]         tbl_raddr,
  input  logic [FLAG_W+PORT_W-1:0] tbl_rdata,
  output logic                     lk_valid,
  output logic [PORT_W-1:0]        lk_mask,
  output logic [FLAG_W-1:0]        lk_flags
);
  assign tbl_raddr = lk_vid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_valid <= 1'b0;
      lk_mask  <= '0;
      lk_flags <= '0;
    end else begin
      lk_valid <= lk_req;
      if (lk_req) begin
        if (sweep_act) begin
          lk_mask  <= '1;
          lk_flags <= '0;
        end else begin
          lk_mask  <= tbl_rdata[PORT_W-1:0];
          lk_flags <= tbl_rdata[PORT_W +: FLAG_W];
        end
      end
    end
  end

  AST_LK_SWEEP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && sweep_act) |=> (lk_valid && (&lk_mask) && lk_flags == '0)); // R10

  AST_LK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_valid); // R9

  AST_LK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_valid); // R9

endmodule

// File: rtl/vlan_tbl_ctrl.sv
module vlan_tbl_ctrl #(
  parameter int VID_W  = 12,
  parameter int PORT_W = 10,
  parameter int FLAG_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [1:0]            reg_addr,
  input  logic [VID_W+FLAG_W:0] reg_wdata,
  output logic [VID_W+FLAG_W:0] reg_rdata,
  input  logic                  lk_req,
  input  logic [VID_W-1:0]      lk_vid,
  output logic                  lk_valid,
  output logic [PORT_W-1:0]     lk_mask,
  output logic [FLAG_W-1:0]     lk_flags
);
  localparam int ENT_W = FLAG_W + PORT_W;

  logic             tbl_we;
  logic [VID_W-1:0] tbl_waddr;
  logic [ENT_W-1:0] tbl_wdata;
  logic [VID_W-1:0] sw_raddr;
  logic [ENT_W-1:0] sw_rdata;
  logic [VID_W-1:0] lk_raddr;
  logic [ENT_W-1:0] lk_rdata;
  logic             sweep_act;

  vlan_cmd_seq #(.VID_W(VID_W), .PORT_W(PORT_W), .FLAG_W(FLAG_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tbl_we    (tbl_we),
    .tbl_waddr (tbl_waddr),
    .tbl_wdata (tbl_wdata),
    .tbl_raddr (sw_raddr),
    .tbl_rdata (sw_rdata),
    .sweep_act (sweep_act)
  );

  vlan_tbl_store #(.VID_W(VID_W), .ENT_W(ENT_W)) u_store (
    .clk     (clk),
    .we      (tbl_we),
    .waddr   (tbl_waddr),
    .wdata   (tbl_wdata),
    .raddr_a (sw_raddr),
    .rdata_a (sw_rdata),
    .raddr_b (lk_raddr),
    .rdata_b (lk_rdata)
  );

  vlan_lookup #(.VID_W(VID_W), .PORT_W(PORT_W), .FLAG_W(FLAG_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_vid    (lk_vid),
    .sweep_act (sweep_act),
    .tbl_raddr (lk_raddr),
    .tbl_rdata (lk_rdata),
    .lk_valid  (lk_valid),
    .lk_mask   (lk_mask),
    .lk_flags  (lk_flags)
  );

endmodule

// File: tb/vlan_tbl_ctrl_tb.sv
module vlan_tbl_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [18:0] reg_wdata = '0;
  logic [18:0] reg_rdata;
  logic        lk_req = 1'b0;
  logic [11:0] lk_vid = '0;
  logic        lk_valid;
  logic [9:0]  lk_mask;
  logic [5:0]  lk_flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlan_tbl_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
    .lk_vid(lk_vid), .lk_valid(lk_valid), .lk_mask(lk_mask), .lk_flags(lk_flags)
  );

  // vid, flags, cpu_dis, mask written, mask expected in the entry
  localparam logic [38:0] VEC [6] = '{
    {12'd1,    6'h01, 1'b0, 10'h3FF, 10'h3FF},
    {12'd100,  6'h2A, 1'b1, 10'h3FF, 10'h1FF},
    {12'd4095, 6'h3F, 1'b0, 10'h000, 10'h000},
    {12'd0,    6'h15, 1'b0, 10'h201, 10'h201},
    {12'd2048, 6'h00, 1'b1, 10'h155, 10'h155},
    {12'd4000, 6'h33, 1'b0, 10'h0F0, 10'h0F0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [18:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [18:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic lookup_chk(input logic [11:0] vid, input logic [9:0] em, input logic [5:0] ef, input string req);
    lk_req = 1'b1; lk_vid = vid;
    @(negedge clk);
    check({req, " lookup valid"}, {31'd0, lk_valid}, 32'd1);
    check({req, " lookup mask"},  {22'd0, lk_mask}, {22'd0, em});
    check({req, " lookup flags"}, {26'd0, lk_flags}, {26'd0, ef});
    lk_req = 1'b0;
    @(negedge clk);
    check("R9 valid drops without request", {31'd0, lk_valid}, 32'd0);
  endtask

  // Starts an initialise and counts the busy samples; optional side stimulus.
  task automatic run_init(input bit side, output int n);
    logic [18:0] d;
    reg_write(2'd2, 19'd3);
    n = 0;
    for (int c = 0; c < 6000; c++) begin
      reg_wr = 1'b0; reg_addr = 2'd2;
      if (side && c == 2) begin lk_req = 1'b1; lk_vid = 12'd4000; end
      if (side && c == 3) begin
        check("R10 sweep lookup valid", {31'd0, lk_valid}, 32'd1);
        check("R10 sweep lookup mask", {22'd0, lk_mask}, 32'h3FF);
        check("R10 sweep lookup flags", {26'd0, lk_flags}, 32'd0);
        lk_req = 1'b0;
      end
      if (side && c == 10) begin reg_wr = 1'b1; reg_wdata = 19'd2; end
      if (side && c == 20) begin reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 19'h7F123; end
      #1;
      d = reg_rdata;
      if (!(side && c == 20) && d[1:0] != 2'd3) break;
      n++;
      @(negedge clk);
    end
    reg_wr = 1'b0;
  endtask

  initial begin
    logic [18:0] d;
    logic [18:0] prev_idx;
    logic [11:0] vid;
    logic [5:0]  flg;
    logic        cd;
    logic [9:0]  msk, expm;
    int n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(2'd0, d); check("R1 reset index", {13'd0, d}, 32'd0);
    reg_read(2'd1, d); check("R1 reset mask", {13'd0, d}, 32'd0);
    reg_read(2'd2, d); check("R1 reset command", {13'd0, d}, 32'd0);
    check("R1 reset lk_valid", {31'd0, lk_valid}, 32'd0);

    run_init(1'b0, n);
    check("R7 first init busy cycles", n, 32'd4096);
    lookup_chk(12'd7, 10'h3FF, 6'h00, "R6 after init");

    for (int i = 0; i < 6; i++) begin
      {vid, flg, cd, msk, expm} = VEC[i];
      reg_write(2'd0, {cd, flg, vid});
      reg_write(2'd1, {9'd0, msk});
      reg_write(2'd2, 19'd2);
      reg_read(2'd2, d); check("R5 write shows command", {13'd0, d}, 32'd2);
      @(negedge clk);
      reg_read(2'd2, d); check("R5 write back to idle", {13'd0, d}, 32'd0);
      reg_write(2'd0, {1'b1, 6'h00, vid});
      reg_write(2'd1, 19'd0);
      reg_write(2'd2, 19'd1);
      reg_read(2'd2, d); check("R5 read shows command", {13'd0, d}, 32'd1);
      @(negedge clk);
      reg_read(2'd2, d); check("R5 read back to idle", {13'd0, d}, 32'd0);
      reg_read(2'd0, d); check("R4 read index flags/cpu_dis/vid", {13'd0, d}, {13'd0, ~expm[9], flg, vid});
      reg_read(2'd1, d); check("R3 stored mask", {13'd0, d}, {22'd0, expm});
      lookup_chk(vid, expm, flg, "R9 R3 entry");
    end

    reg_read(2'd0, prev_idx);
    reg_write(2'd2, 19'd0);
    reg_read(2'd2, d); check("R2 idle command stays idle", {13'd0, d}, 32'd0);
    reg_read(2'd0, d); check("R2 idle command leaves index", {13'd0, d}, {13'd0, prev_idx});

    run_init(1'b1, n);
    check("R7 second init busy cycles", n, 32'd4096);
    @(negedge clk);
    reg_read(2'd2, d); check("R8 no command queued", {13'd0, d}, 32'd0);
    reg_read(2'd0, d); check("R8 index unchanged while busy", {13'd0, d}, {13'd0, prev_idx});
    reg_write(2'd2, 19'd1);
    @(negedge clk);
    reg_read(2'd1, d); check("R6 entry 4000 mask", {13'd0, d}, 32'h3FF);
    reg_read(2'd0, d); check("R6 entry 4000 flags", {26'd0, d[17:12]}, 32'd0);
    lookup_chk(12'd0, 10'h3FF, 6'h00, "R6 entry 0");
    lookup_chk(12'd4095, 10'h3FF, 6'h00, "R6 entry 4095");
    lookup_chk(12'd100, 10'h3FF, 6'h00, "R6 entry 100");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule